// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a flash array. After a program or erase command has been written, the host pulses `go` with an address. The poller then reads that address over and over until the flash stops reporting activity. The array signals that it is busy by flipping a status bit on every read. Once two back-to-back reads return the same byte, the operation has finished. The block then raises `done` for one cycle, together with a pass or fail verdict and the last byte it read.

There is a second status bit that marks a failure, and the array may set it in the same read in which it completes. A failure bit seen while the busy bit is still flipping is therefore not trusted on its own. The poller takes two confirmation reads and rules on those alone. A read-count watchdog stops a run that never settles and reports it as a timeout.

The read channel follows valid/ready rules. `req_valid` and `req_addr` are held steady until the cycle in which `req_ready` is high, and that cycle is the transfer. After a transfer, no new request appears until `rsp_valid` has delivered the byte. The poller takes the response in any cycle; it has no ready signal, so back-pressure exists only on the request side.

Top module: `flash_poll_top`

## Requirements
- R1: After reset, `done`, `pass`, `timeout` and `req_valid` are 0 and `last_data` is all zeros.
- R2: A `go` pulse while idle starts a run. Every request in that run carries the `go_addr` captured at the start.
- R3: A request stays asserted with a stable address until `req_ready` is high. At most one request is outstanding, so no request is raised between a transfer and its response.
- R4: When two consecutive reads of a run return identical bytes, the run ends with `done` high and `pass` = 1.
- R5: If consecutive reads differ and bit 6 flips between them with bit 5 of the newer read clear, polling continues. Polling also continues when the reads differ with bit 6 unchanged, whatever bit 5 is.
- R6: If consecutive reads differ in bit 6 and bit 5 of the newer read is 1, exactly two further reads are made. The run fails (`pass` = 0, `timeout` = 0) if bit 6 differs between those two reads.
- R7: In the confirmation case of R6, the run passes if bit 6 is equal in the two confirmation reads, even when other bits differ.
- R8: When the POLL_LIMIT-th read of a run brings no verdict, the run ends with `pass` = 0 and `timeout` = 1.
- R9: `done` is high for exactly one cycle per run. `pass`, `timeout` and `last_data` (the most recent byte read) then hold until new read data arrives after the next `go`, and the next `go` clears `pass` and `timeout`.
- R10: A `go` pulse during a run is ignored. It changes neither the address nor the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start pulse, honoured only while idle |
| go_addr | input | AW | Address to poll |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | AW | Read address |
| rsp_valid | input | 1 | Read data valid, one cycle per accepted request |
| rsp_data | input | DW | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Verdict: operation completed cleanly |
| timeout | output | 1 | Verdict: watchdog limit reached |
| last_data | output | DW | Most recent byte read |

## Verification
The hardest situation to reach from the ports is a failure bit that shows up together with a flipping busy bit, followed by confirmation reads that either keep flipping or settle. That case splits into a real failure and a late completion. The bench model answers requests from a per-case byte sequence, which lets it place the failure bit on exactly the second read. The next two bytes then decide the outcome, and one case settles bit 6 while changing other bits. A case that keeps flipping forever drives the read counter to its limit. A ready signal that stalls two cycles in three exercises the hold rules of the request channel.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  // Confirmation phase after a suspicious failure flag
  typedef enum logic [1:0] {
    CF_NONE   = 2'd0,
    CF_FIRST  = 2'd1,
    CF_SECOND = 2'd2
  } confirm_t;

  // Action taken on an accepted response
  typedef enum logic [2:0] {
    ACT_ISSUE,
    ACT_CONFIRM,
    ACT_PASS,
    ACT_FAIL,
    ACT_TMO
  } act_t;

endpackage

// File: rtl/flash_poll_req.sv
// Holds one read request on a valid/ready channel until it is accepted.
module flash_poll_req #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          issue,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic          fire
);

  assign fire = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else begin
      if (load)
        addr <= load_addr;
      if (issue)
        valid <= 1'b1;
      else if (fire)
        valid <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_poll_classify.sv
// Compares a fresh status byte with the previous one.
module flash_poll_classify #(
  parameter int DW      = 8,
  parameter int TGL_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] prev,
  output logic          same,
  output logic          toggled,
  output logic          err
);

  logic [DW-1:0] diff;

  generate
    if (TGL_BIT >= DW || ERR_BIT >= DW) begin : g_bad
      initial $error("status bit index outside data width");
    end
  endgenerate

  assign diff    = cur ^ prev;
  assign same    = (diff == '0);
  assign toggled = diff[TGL_BIT];
  assign err     = cur[ERR_BIT];

endmodule

// File: rtl/flash_poll_watchdog.sv
// Counts reads of a run and flags the last one allowed.
module flash_poll_watchdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic last_allowed
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign last_allowed = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (tick && !last_allowed)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/flash_poll_top.sv
module flash_poll_top
  import flash_poll_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int TGL_BIT    = 6,
  parameter int ERR_BIT    = 5,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output logic          pass,
  output logic          timeout,
  output logic [DW-1:0] last_data
);

  logic     busy;
  logic     first;
  confirm_t conf;
  logic     start;
  logic     take;
  logic     issue;
  logic     fire;
  logic     same, toggled, err;
  logic     wd_last;
  act_t     act;

  assign start = go && !busy;
  assign take  = busy && !req_valid && rsp_valid;

  flash_poll_req #(.AW(AW)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_addr (go_addr),
    .issue     (issue),
    .ready     (req_ready),
    .valid     (req_valid),
    .addr      (req_addr),
    .fire      (fire)
  );

  flash_poll_classify #(.DW(DW), .TGL_BIT(TGL_BIT), .ERR_BIT(ERR_BIT)) u_cls (
    .cur     (rsp_data),
    .prev    (last_data),
    .same    (same),
    .toggled (toggled),
    .err     (err)
  );

  flash_poll_watchdog #(.LIMIT(POLL_LIMIT)) u_wd (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (start),
    .tick         (take),
    .last_allowed (wd_last)
  );

  // Verdict for the response being taken this cycle
  always_comb begin
    act = ACT_ISSUE;
    if (conf == CF_FIRST)
      act = ACT_ISSUE;
    else if (conf == CF_SECOND)
      act = toggled ? ACT_FAIL : ACT_PASS;
    else if (first)
      act = ACT_ISSUE;
    else if (same)
      act = ACT_PASS;
    else if (toggled && err)
      act = ACT_CONFIRM;
    else if (wd_last)
      act = ACT_TMO;
    else
      act = ACT_ISSUE;
  end

  assign issue = start || (take && (act == ACT_ISSUE || act == ACT_CONFIRM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      first     <= 1'b0;
      conf      <= CF_NONE;
      done      <= 1'b0;
      pass      <= 1'b0;
      timeout   <= 1'b0;
      last_data <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        first   <= 1'b1;
        conf    <= CF_NONE;
        pass    <= 1'b0;
        timeout <= 1'b0;
      end else if (take) begin
        last_data <= rsp_data;
        first     <= 1'b0;
        unique case (act)
          ACT_CONFIRM: conf <= CF_FIRST;
          ACT_ISSUE: begin
            if (conf == CF_FIRST)
              conf <= CF_SECOND;
          end
          ACT_PASS, ACT_FAIL, ACT_TMO: begin
            busy    <= 1'b0;
            conf    <= CF_NONE;
            done    <= 1'b1;
            pass    <= (act == ACT_PASS);
            timeout <= (act == ACT_TMO);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          done,
  input logic          pass,
  input logic          timeout,
  input logic [DW-1:0] last_data
);

  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      outst <= 1'b0;
    else if (req_valid && req_ready)
      outst <= 1'b1;
    else if (rsp_valid)
      outst <= 1'b0;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R3
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !outst);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(last_data));

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(pass && timeout));

endmodule

bind flash_poll_top flash_poll_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/flash_poll_top_test.sv
`timescale 1ns/1ps
module flash_poll_top_test;

  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct packed {
    logic [31:0] data;     // byte k at bits 8k+7:8k, replayed cyclically
    logic [2:0]  len;
    logic        stall;
    logic        exp_pass;
    logic        exp_tmo;
    logic [4:0]  exp_reads;
    logic [7:0]  exp_last;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h55550040, 3'd4, 1'b0, 1'b1, 1'b0, 5'd4,  8'h55}, // R4 R5 toggle then settle
    '{32'h00001212, 3'd2, 1'b0, 1'b1, 1'b0, 5'd2,  8'h12}, // R4 immediate match
    '{32'h20602040, 3'd4, 1'b0, 1'b0, 1'b0, 5'd4,  8'h20}, // R6 real failure
    '{32'hA5A52040, 3'd4, 1'b0, 1'b1, 1'b0, 5'd4,  8'hA5}, // R7 late completion
    '{32'h00000040, 3'd2, 1'b0, 1'b0, 1'b1, 5'd10, 8'h00}, // R8 never settles
    '{32'h00000080, 3'd3, 1'b0, 1'b1, 1'b0, 5'd3,  8'h00}, // R5 non-toggle diff
    '{32'h00303020, 3'd3, 1'b0, 1'b1, 1'b0, 5'd3,  8'h30}, // R5 err without toggle
    '{32'h55550040, 3'd4, 1'b1, 1'b1, 1'b0, 5'd4,  8'h55}, // R3 stalled ready
    '{32'hA4A52040, 3'd4, 1'b0, 1'b1, 1'b0, 5'd4,  8'hA4}  // R7 bit6 only decides
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [AW-1:0] go_addr = '0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic          done, pass, timeout;
  logic [DW-1:0] last_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0]   cur_data = '0;
  int            cur_len = 1;
  logic          cur_stall = 1'b0;
  int            hs_cnt = 0;
  int            bad_addr = 0;
  logic [AW-1:0] exp_addr = '0;
  int            cyc = 0;
  logic          pend = 1'b0;

  always #5 clk = ~clk;

  flash_poll_top #(.AW(AW), .DW(DW), .POLL_LIMIT(10)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .pass(pass), .timeout(timeout), .last_data(last_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory model: answers one cycle after each accepted request
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      if (pend) begin
        rsp_valid = 1'b1;
        rsp_data  = cur_data[8*((hs_cnt-1) % cur_len) +: 8];
        pend      = 1'b0;
      end
      req_ready = !cur_stall || (cyc % 3 == 0);
      if (req_valid && req_ready) begin
        pend = 1'b1;
        hs_cnt++;
        if (req_addr !== exp_addr) bad_addr++;
      end
    end
  end

  task automatic start_run(input logic [31:0] d, input int len, input logic st,
                           input logic [AW-1:0] a);
    cur_data = d; cur_len = len; cur_stall = st;
    hs_cnt = 0; bad_addr = 0; exp_addr = a;
    @(negedge clk); go = 1'b1; go_addr = a;
    @(negedge clk); go = 1'b0; go_addr = '0;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done && waited < 400) begin
      @(negedge clk);
      waited++;
      // R10: stray start pulse in the middle of the run
      if (waited == 3) begin go = 1'b1; go_addr = 16'hDEAD; end
      else begin go = 1'b0; go_addr = '0; end
    end
    go = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    vec_t v;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 pass", pass, 0);
    chk("R1 timeout", timeout, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 last_data", last_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      start_run(v.data, int'(v.len), v.stall, AW'(16'h1000 + i));
      wait_done(w);
      chk("R4 R6 R7 R8 done seen", done, 1);
      chk("R4 R6 R7 pass", pass, v.exp_pass);
      chk("R8 timeout", timeout, v.exp_tmo);
      chk("R9 last_data", last_data, v.exp_last);
      chk("R3 R5 R6 read count", hs_cnt, v.exp_reads);
      chk("R2 R10 address", bad_addr, 0);
      @(negedge clk);
      chk("R9 done one cycle", done, 0);
      repeat (4) @(negedge clk);
      chk("R9 pass held", pass, v.exp_pass);
      chk("R9 last_data held", last_data, v.exp_last);
    end

    // R9: next go clears the verdict; last_data waits for new data
    keep = last_data;
    cur_data = 32'h00007777; cur_len = 2; cur_stall = 1'b1;
    hs_cnt = 0; bad_addr = 0; exp_addr = 16'h2222;
    @(negedge clk); go = 1'b1; go_addr = 16'h2222;
    @(negedge clk); go = 1'b0; go_addr = '0;
    chk("R9 go clears pass", pass, 0);
    chk("R9 go keeps last_data", last_data, keep);
    chk("R2 request raised", req_valid, 1);
    chk("R2 request address", req_addr, 16'h2222);
    wait_done(w);
    chk("R4 pass after clear", pass, 1);
    chk("R4 last after clear", last_data, 8'h77);
    chk("R3 reads stalled", hs_cnt, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule